// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor core. A rising edge on a line is captured into a pending flag. Pending lines that are enabled become posted one cycle later. The posted lines compete in a fixed three-clock priority evaluation. The winning line is then offered to the core as a request, together with its line number and its service-routine vector address.

The core accepts the request with an acknowledge strobe. The controller then drops the request and clears the winner's pending flag, and clears its posted flag on the next cycle. The winner becomes the active interrupt. The state that was active before it is pushed onto a nesting stack. A more urgent line may interrupt the active one. When the core signals that a service routine has finished, the controller restores the active state it held before that interrupt was taken.

Each line has a 3-bit priority, where a smaller value is more urgent. Each line also has its own vector register and its own enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line that goes from low to high sets its pending flag on the next clock edge. A line held high does not pend again. When the controller is idle and the line is enabled and eligible, req_o is high at the fifth falling clock edge after the rise is driven, with the rise driven just after a falling edge.
- R2: Among eligible posted lines, the one with the smallest priority value (prio_i[3k+2:3k] for line k) wins. On a tie, the lower line index wins.
- R3: Once req_o is high it stays high until a clock edge samples ack_i high. On that edge req_o drops.
- R4: While req_o is high, act_num_o holds the requesting line index k and vec_o holds vec_i[16k+15:16k]. After the acknowledge, both show the now-active line.
- R5: When nothing is requested and nothing is active, act_num_o and vec_o are zero.
- R6: A disabled line can pend but is never requested. If it is enabled later while still pending, it is then requested.
- R7: While an interrupt is active, a new request is issued only for a line whose priority value is strictly smaller. A line of equal or lower urgency waits.
- R8: A clock edge with done_i high restores the active line to the one that was active before the current one was taken, or to none. A waiting line that becomes eligible is requested afterwards.
- R9: An acknowledged line is not requested again until it shows a new rising edge.
- R10: done_i has no effect when no interrupt is active, or on the same edge on which an acknowledge is accepted.
- R11: After synchronous reset, req_o is low, act_num_o and vec_o are zero, and no line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Raw interrupt lines, edge sensitive |
| irq_en_i | input | 32 | Per-line enable |
| prio_i | input | 96 | Per-line 3-bit priority, line k at bits 3k+2:3k, smaller is more urgent |
| vec_i | input | 512 | Per-line 16-bit vector address, line k at bits 16k+15:16k |
| ack_i | input | 1 | Core acknowledge of the current request |
| done_i | input | 1 | Core service-routine completion strobe |
| req_o | output | 1 | Interrupt request to the core |
| act_num_o | output | 5 | Requesting line while req_o is high, otherwise the active line, otherwise zero |
| vec_o | output | 16 | Vector address of the line shown on act_num_o, otherwise zero |

## Verification
The bench raises two lines in the same cycle, once with equal priorities and once with different ones. A selector with the wrong comparison or the wrong tie order would name the wrong line. It then nests a more urgent interrupt over an active one, and also raises a line of equal priority. A controller that preempts on equal priority would issue an extra request. One that pops its stack incorrectly would report the wrong line after completion, or would lose the deferred line. It also holds a line high across its own acknowledge, strobes completion while idle, and strobes completion together with an acknowledge. Here a level-sensitive capture would re-request the line, and a completion that is not gated would corrupt the active state. A disabled line that later becomes enabled exposes any design that drops the pending flag or posts it while disabled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_LINES_DEF = 32;
    localparam int PRIO_W_DEF    = 3;
    localparam int VEC_W_DEF     = 16;
    localparam int EVAL_CYCLES   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_REQ  = 2'd2,
        ST_CLR  = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int NUM = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] line_i,
    input  logic [NUM-1:0] en_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] pend_o,
    output logic [NUM-1:0] post_o
);

    logic [NUM-1:0] prev_q;
    logic [NUM-1:0] pend_q;
    logic [NUM-1:0] post_q;

    for (genvar g = 0; g < NUM; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
                post_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= line_i[g];
                // a fresh edge wins over a same-cycle clear
                pend_q[g] <= (pend_q[g] & ~clr_i[g]) | (line_i[g] & ~prev_q[g]);
                post_q[g] <= pend_q[g] & en_i[g];
            end
        end

        a_r1_pend_on_rise: assert property (@(posedge clk) disable iff (rst)
            (line_i[g] && !prev_q[g]) |=> pend_q[g]);
    end

    assign pend_o = pend_q;
    assign post_o = post_q;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM  = 32,
    parameter int PW   = 3,
    parameter int ID_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]    elig_i,
    input  logic [NUM*PW-1:0] prio_i,
    output logic              win_v_o,
    output logic [ID_W-1:0]   win_id_o,
    output logic [PW-1:0]     win_prio_o
);

    always_comb begin
        win_v_o    = 1'b0;
        win_id_o   = '0;
        win_prio_o = '1;
        for (int i = 0; i < NUM; i++) begin
            // strict compare keeps the lower index on a tie
            if (elig_i[i] && (!win_v_o || prio_i[i*PW +: PW] < win_prio_o)) begin
                win_v_o    = 1'b1;
                win_id_o   = ID_W'(i);
                win_prio_o = prio_i[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
    parameter int DEPTH = 8,
    parameter int EW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [EW-1:0] din_i,
    output logic [EW-1:0] top_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [EW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[AW'(cnt_q)] <= din_i;
        end
    end

    assign top_o = (cnt_q == '0) ? '0 : mem_q[AW'(cnt_q - 1'b1)];

    a_r7_stack_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (cnt_q < CW'(DEPTH)));
    a_r8_stack_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_LINES  = irqc_pkg::NUM_LINES_DEF,
    parameter int PRIO_W     = irqc_pkg::PRIO_W_DEF,
    parameter int VEC_W      = irqc_pkg::VEC_W_DEF,
    localparam int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES-1:0]        irq_i,
    input  logic [NUM_LINES-1:0]        irq_en_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    input  logic [NUM_LINES*VEC_W-1:0]  vec_i,
    input  logic                        ack_i,
    input  logic                        done_i,
    output logic                        req_o,
    output logic [ID_W-1:0]             act_num_o,
    output logic [VEC_W-1:0]            vec_o
);

    import irqc_pkg::*;

    localparam int STK_D = 1 << PRIO_W;
    localparam int ENT_W = 1 + ID_W + PRIO_W;
    localparam int CNT_W = 2;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_t;

    ctl_state_e            st_q;
    logic [CNT_W-1:0]      cnt_q;
    act_t                  cand_q;
    act_t                  cur_q;
    act_t                  stk_top;
    logic [NUM_LINES-1:0]  pend;
    logic [NUM_LINES-1:0]  post;
    logic [NUM_LINES-1:0]  elig;
    logic [NUM_LINES-1:0]  clr_pend;
    logic                  win_v;
    logic [ID_W-1:0]       win_id;
    logic [PRIO_W-1:0]     win_prio;
    logic                  take;
    logic                  pop;
    logic                  show_v;
    logic [ID_W-1:0]       show_id;

    irqc_capture #(.NUM(NUM_LINES)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .line_i (irq_i),
        .en_i   (irq_en_i),
        .clr_i  (clr_pend),
        .pend_o (pend),
        .post_o (post)
    );

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            elig[i] = post[i] & irq_en_i[i] &
                      (!cur_q.valid || (prio_i[i*PRIO_W +: PRIO_W] < cur_q.prio));
        end
    end

    irqc_arbiter #(.NUM(NUM_LINES), .PW(PRIO_W), .ID_W(ID_W)) u_arbiter (
        .elig_i     (elig),
        .prio_i     (prio_i),
        .win_v_o    (win_v),
        .win_id_o   (win_id),
        .win_prio_o (win_prio)
    );

    assign take = (st_q == ST_REQ) && ack_i;
    assign pop  = done_i && cur_q.valid && !take;

    always_comb begin
        clr_pend = '0;
        if (take) begin
            clr_pend[cand_q.id] = 1'b1;
        end
    end

    irqc_stack #(.DEPTH(STK_D), .EW(ENT_W)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push_i (take),
        .pop_i  (pop),
        .din_i  (cur_q),
        .top_o  (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            cand_q <= '0;
            cur_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (win_v) begin
                    cand_q <= '{valid: 1'b1, id: win_id, prio: win_prio};
                    cnt_q  <= '0;
                    st_q   <= ST_EVAL;
                end
                ST_EVAL: if (cnt_q == CNT_W'(EVAL_CYCLES - 2)) begin
                    st_q <= ST_REQ;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_REQ:  if (ack_i) st_q <= ST_CLR;
                ST_CLR:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
            if (take) begin
                cur_q <= cand_q;
            end else if (pop) begin
                cur_q <= stk_top;
            end
        end
    end

    assign req_o     = (st_q == ST_REQ);
    assign show_v    = req_o || cur_q.valid;
    assign show_id   = req_o ? cand_q.id : cur_q.id;
    assign act_num_o = show_v ? show_id : '0;
    assign vec_o     = show_v ? vec_i[show_id*VEC_W +: VEC_W] : '0;

    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> req_o);
    a_r3_req_drop: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i) |=> !req_o);
    a_r7_strict_preempt: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o) && cur_q.valid) |-> (cand_q.prio < cur_q.prio));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!req_o && !cur_q.valid) |-> (act_num_o == '0 && vec_o == '0));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int N  = 32;
    localparam int PW = 3;
    localparam int VW = 16;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    irq = '0;
    logic [N-1:0]    en  = '1;
    logic [N*PW-1:0] prio_bus = '1;
    logic [N*VW-1:0] vec_bus;
    logic            ack  = 1'b0;
    logic            done = 1'b0;
    logic            req_o;
    logic [IW-1:0]   act_num_o;
    logic [VW-1:0]   vec_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_i     (irq),
        .irq_en_i  (en),
        .prio_i    (prio_bus),
        .vec_i     (vec_bus),
        .ack_i     (ack),
        .done_i    (done),
        .req_o     (req_o),
        .act_num_o (act_num_o),
        .vec_o     (vec_o)
    );

    // ---------------- reference model ----------------
    int m_pend[N];
    int m_post[N];
    int m_prev[N];
    int m_st, m_cnt, m_cid, m_cprio;
    int cur_v, cur_id, cur_p;
    int sv[$];
    int sid[$];
    int sp[$];

    function automatic int pr(int k);
        return int'(prio_bus[k*PW +: PW]);
    endfunction

    function automatic int vecv(int k);
        return int'(vec_bus[k*VW +: VW]);
    endfunction

    always @(posedge clk) begin
        int bw, bp;
        int np[N];
        bit tk, pp;
        cycles++;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_post[i] = 0; m_prev[i] = 0;
            end
            m_st = 0; m_cnt = 0; m_cid = 0; m_cprio = 0;
            cur_v = 0; cur_id = 0; cur_p = 0;
            sv.delete(); sid.delete(); sp.delete();
        end else begin
            tk = (m_st == 2) && ack;
            pp = done && (cur_v != 0) && !tk;
            bw = -1; bp = 99;
            for (int i = 0; i < N; i++) begin
                if (m_post[i] != 0 && en[i] && (cur_v == 0 || pr(i) < cur_p) && pr(i) < bp) begin
                    bw = i; bp = pr(i);
                end
            end
            for (int i = 0; i < N; i++) begin
                np[i] = (tk && i == m_cid) ? 0 : m_pend[i];
                if (irq[i] && m_prev[i] == 0) np[i] = 1;
                m_post[i] = (m_pend[i] != 0 && en[i]) ? 1 : 0;
                m_prev[i] = irq[i] ? 1 : 0;
            end
            for (int i = 0; i < N; i++) m_pend[i] = np[i];
            if (tk) begin
                sv.push_back(cur_v); sid.push_back(cur_id); sp.push_back(cur_p);
                cur_v = 1; cur_id = m_cid; cur_p = m_cprio;
            end else if (pp) begin
                cur_v = sv.pop_back(); cur_id = sid.pop_back(); cur_p = sp.pop_back();
            end
            case (m_st)
                0: if (bw >= 0) begin m_cid = bw; m_cprio = bp; m_cnt = 0; m_st = 1; end
                1: if (m_cnt == 1) m_st = 2; else m_cnt++;
                2: if (ack) m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        int e_req, e_num, e_vec;
        if (!rst) begin
            e_req = (m_st == 2) ? 1 : 0;
            e_num = e_req ? m_cid : (cur_v ? cur_id : 0);
            e_vec = e_req ? vecv(m_cid) : (cur_v ? vecv(cur_id) : 0);
            chk(int'(req_o) == e_req, "R3", "req_o vs model", int'(req_o), e_req);
            chk(int'(act_num_o) == e_num, "R4", "act_num_o vs model", int'(act_num_o), e_num);
            chk(int'(vec_o) == e_vec, "R4", "vec_o vs model", int'(vec_o), e_vec);
        end
    end

    always @(posedge clk) begin
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 60000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic setp(int k, int p);
        prio_bus[k*PW +: PW] = PW'(p);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int k);
        irq[k] = 1'b1;
        @(negedge clk);
        irq[k] = 1'b0;
    endtask

    task automatic wait_req(int maxc);
        int c = 0;
        while (!req_o && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        int lat;
        for (int i = 0; i < N; i++) vec_bus[i*VW +: VW] = VW'(16'h0400 + i * 16);
        tick(3);
        rst = 1'b0;
        tick(1);
        // R11 reset state
        chk(req_o == 1'b0, "R11", "req after reset", int'(req_o), 0);
        chk(act_num_o == '0 && vec_o == '0, "R11", "outputs after reset", int'(vec_o), 0);
        tick(5);
        chk(req_o == 1'b0, "R11", "no pending after reset", int'(req_o), 0);

        // R1 latency, R4 fields, R3 hold/drop
        setp(5, 3);
        irq[5] = 1'b1;
        lat = 0;
        while (!req_o && lat < 20) begin
            @(negedge clk);
            lat++;
            irq[5] = 1'b0;
        end
        chk(lat == 5, "R1", "request latency", lat, 5);
        chk(act_num_o == 5, "R4", "number with request", int'(act_num_o), 5);
        chk(int'(vec_o) == vecv(5), "R4", "vector with request", int'(vec_o), vecv(5));
        tick(6);
        chk(req_o == 1'b1, "R3", "request held without ack", int'(req_o), 1);
        do_ack();
        chk(req_o == 1'b0, "R3", "request dropped after ack", int'(req_o), 0);
        chk(act_num_o == 5, "R4", "active number after ack", int'(act_num_o), 5);
        do_done();
        chk(act_num_o == 0 && vec_o == 0, "R5", "idle after completion", int'(act_num_o), 0);

        // R2 tie on equal priority
        setp(9, 2); setp(4, 2);
        irq[9] = 1'b1; irq[4] = 1'b1;
        tick(1);
        irq[9] = 1'b0; irq[4] = 1'b0;
        wait_req(20);
        chk(act_num_o == 4, "R2", "tie goes to lower index", int'(act_num_o), 4);
        do_ack(); do_done();
        wait_req(20);
        chk(req_o && act_num_o == 9, "R2", "second tied line follows", int'(act_num_o), 9);
        do_ack(); do_done();

        // R2 different priorities
        setp(20, 1); setp(3, 4);
        irq[20] = 1'b1; irq[3] = 1'b1;
        tick(1);
        irq[20] = 1'b0; irq[3] = 1'b0;
        wait_req(20);
        chk(act_num_o == 20, "R2", "smaller value wins", int'(act_num_o), 20);
        do_ack(); do_done();
        wait_req(20);
        chk(req_o && act_num_o == 3, "R2", "less urgent line follows", int'(act_num_o), 3);
        do_ack(); do_done();

        // R6 disabled line
        en[7] = 1'b0;
        setp(7, 3);
        pulse(7);
        tick(20);
        chk(req_o == 1'b0, "R6", "disabled line not requested", int'(req_o), 0);
        en[7] = 1'b1;
        wait_req(20);
        chk(req_o && act_num_o == 7, "R6", "pending kept until enabled", int'(act_num_o), 7);
        do_ack(); do_done();

        // R7 / R8 nesting
        setp(10, 5); setp(11, 5); setp(12, 2);
        pulse(10);
        wait_req(20);
        do_ack();
        pulse(11);
        tick(15);
        chk(req_o == 1'b0, "R7", "equal priority does not preempt", int'(req_o), 0);
        chk(act_num_o == 10, "R7", "active kept", int'(act_num_o), 10);
        pulse(12);
        wait_req(20);
        chk(req_o && act_num_o == 12, "R7", "more urgent line preempts", int'(act_num_o), 12);
        do_ack();
        tick(2);
        do_done();
        chk(act_num_o == 10, "R8", "previous active restored", int'(act_num_o), 10);
        chk(int'(vec_o) == vecv(10), "R8", "restored vector", int'(vec_o), vecv(10));
        do_done();
        wait_req(20);
        chk(req_o && act_num_o == 11, "R8", "deferred line requested", int'(act_num_o), 11);
        do_ack(); do_done();
        chk(act_num_o == 0, "R8", "stack empties to idle", int'(act_num_o), 0);

        // R10 completion ignored
        tick(3);
        do_done();
        chk(act_num_o == 0 && req_o == 1'b0, "R10", "done while idle ignored", int'(act_num_o), 0);
        setp(14, 4);
        pulse(14);
        wait_req(20);
        ack = 1'b1; done = 1'b1;
        @(negedge clk);
        ack = 1'b0; done = 1'b0;
        chk(act_num_o == 14, "R10", "done with ack ignored", int'(act_num_o), 14);
        do_done();
        chk(act_num_o == 0, "R10", "later done completes", int'(act_num_o), 0);

        // R9 held level does not re-request
        setp(6, 3);
        irq[6] = 1'b1;
        wait_req(20);
        do_ack(); do_done();
        tick(15);
        chk(req_o == 1'b0, "R9", "held line not requested again", int'(req_o), 0);
        irq[6] = 1'b0;
        tick(2);
        pulse(6);
        wait_req(20);
        chk(req_o && act_num_o == 6, "R9", "new edge requests again", int'(act_num_o), 6);
        do_ack(); do_done();
        tick(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule